// File: doc/BRIEF.md
# Serial MAC-PHY Interrupt Request Controller

This block sits on the device side of a serial MAC-PHY link and drives the active-low interrupt line toward the SPI host. Each data transfer ends with a footer that reports three things: how many receive chunks are waiting, how many transmit credits are free, and whether an extended-status event is pending. The block records which of these the last footer reported as empty. If one of them then becomes non-empty before the next transfer begins, the block pulls the interrupt line low. The host answers by starting a transfer. The first data header of that transfer releases the line and disarms the detection until the next footer re-arms it.

Events from the MAC and the PHY collect in a sticky status register that software clears by writing ones. A mask register decides which error sources count toward the extended-status indication. The reset-complete event can never be masked.

Top module: `mphy_irq_ctrl`

## Requirements
- R1: If the last footer (a cycle with `ftr_sent_i` high) sampled `rx_cnt_i` as zero, and `rx_cnt_i` is later non-zero in a cycle without a header strobe, `irq_n_o` goes low one clock later.
- R2: If the last footer sampled `tx_cnt_i` as zero, and `tx_cnt_i` is later non-zero in a cycle without a header strobe, `irq_n_o` goes low one clock later.
- R3: If the last footer sampled `exst_o` low, and `exst_o` is later high in a cycle without a header strobe, `irq_n_o` goes low one clock later.
- R4: A cycle with `hdr_rcvd_i` high returns `irq_n_o` to high on the next clock. This takes priority over any firing condition in the same cycle. No new interrupt can fire until the next footer has been sent.
- R5: Status register (address 0) layout: bit 0 is reset complete; bits 1, 2, 3 and 4 hold `err_evt_i` bits 0 to 3 (transmit protocol error, receive buffer overflow, loss of framing, header error). Mask register (address 1) has a 1 in bits 1 to 4 for each masked error source. `exst_o` is high exactly when some status bit is set and its mask bit is clear.
- R6: A pulse on `rst_done_i` sets status bit 0. This bit is never masked: mask bit 0 always reads 0 and cannot be written.
- R7: Status bits are sticky. Writing a one to a status bit clears it, and writing a zero to it has no effect.
- R8: After reset, the status register is 0, the mask register is 0x1E, `exst_o` is low and `irq_n_o` is high.
- R9: An event that arrives in the same cycle as a write that clears its bit leaves the bit set.
- R10: Reads from any address other than 0 and 1 return zero. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt_i | input | 4 | Error event pulses: bit 0 tx protocol, 1 rx overflow, 2 loss of framing, 3 header error |
| rst_done_i | input | 1 | Reset-complete event pulse |
| rx_cnt_i | input | CNT_W | Live count of receive chunks available |
| tx_cnt_i | input | CNT_W | Live count of transmit credits |
| ftr_sent_i | input | 1 | Footer sent; live counts and `exst_o` are taken as reported |
| hdr_rcvd_i | input | 1 | First data header of a transfer received |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data for `reg_addr_i` (combinational) |
| exst_o | output | 1 | Extended-status indication for the footer |
| irq_n_o | output | 1 | Active-low interrupt toward the host |

## Verification
Two collisions can happen in the same clock. In the first, a status event arrives while software writes a one to clear that same bit. In the second, a firing condition appears in the cycle the data header arrives. The bench drives both inputs on the same falling edge for each case. It then checks that the status bit is still set after the write, and that the interrupt line stays high after the header even though the receive count has turned non-zero.

// File: rtl/mphy_irq_pkg.sv
package mphy_irq_pkg;
  localparam int NUM_ERR  = 4;
  localparam int NUM_SRC  = NUM_ERR + 1;
  localparam int B_RSTDN  = 0;
  localparam int STAT_ADR = 0;
  localparam int MASK_ADR = 1;

  typedef struct packed {
    logic rx;
    logic tx;
    logic ex;
  } arm_t;
endpackage

// File: rtl/mphy_evt_status.sv
module mphy_evt_status
  import mphy_irq_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               exst_o
);
  localparam logic [NUM_SRC-1:0] MASK_RST = {{(NUM_SRC-1){1'b1}}, 1'b0};

  logic [NUM_SRC-1:0] stat_q, stat_d, mask_q, mask_d, w1c;
  logic               stat_wr, mask_wr;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:NUM_SRC];
  assign stat_wr = wr_i && (addr_i == AW'(STAT_ADR));
  assign mask_wr = wr_i && (addr_i == AW'(MASK_ADR));

  always_comb begin
    w1c    = stat_wr ? wdata_i[NUM_SRC-1:0] : '0;
    stat_d = (stat_q & ~w1c) | evt_i;
    mask_d = {wdata_i[NUM_SRC-1:1], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      stat_q <= stat_d;
      if (mask_wr) mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign exst_o = |(stat_q & ~mask_q);

  // R9: an event always lands in the status register
  p_evt_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
  // R7: without a status write no bit drops
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R6: reset-complete always raises the extended-status indication
  p_rstdone_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[B_RSTDN] |-> exst_o);
endmodule

// File: rtl/mphy_ftr_track.sv
module mphy_ftr_track
  import mphy_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic             exst_i,
  input  logic             ftr_sent_i,
  input  logic             hdr_rcvd_i,
  output logic             irq_o
);
  arm_t arm_q, arm_d;
  logic irq_q, irq_d, fire;
  logic rx_nz, tx_nz;

  assign rx_nz = (rx_cnt_i != '0);
  assign tx_nz = (tx_cnt_i != '0);

  always_comb begin
    fire = (arm_q.rx && rx_nz) || (arm_q.tx && tx_nz) || (arm_q.ex && exst_i);
    if (ftr_sent_i) begin
      arm_d.rx = !rx_nz;
      arm_d.tx = !tx_nz;
      arm_d.ex = !exst_i;
    end else if (hdr_rcvd_i) begin
      arm_d = '0;
    end else begin
      arm_d = arm_q;
    end
    if (hdr_rcvd_i)  irq_d = 1'b0;
    else if (fire)   irq_d = 1'b1;
    else             irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '1;
      irq_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  p_hdr_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_rcvd_i |=> !irq_q);
  p_rx_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q.rx && rx_nz && !hdr_rcvd_i) |=> irq_q);
  p_tx_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q.tx && tx_nz && !hdr_rcvd_i) |=> irq_q);
  p_ex_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q.ex && exst_i && !hdr_rcvd_i) |=> irq_q);
  // R4: after a header no new interrupt until a footer arrives
  p_no_refire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_rcvd_i && !ftr_sent_i) |=> (arm_q == '0));
endmodule

// File: rtl/mphy_irq_ctrl.sv
module mphy_irq_ctrl
  import mphy_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int AW    = 2,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] err_evt_i,
  input  logic               rst_done_i,
  input  logic [CNT_W-1:0]   rx_cnt_i,
  input  logic [CNT_W-1:0]   tx_cnt_i,
  input  logic               ftr_sent_i,
  input  logic               hdr_rcvd_i,
  input  logic               reg_wr_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               exst_o,
  output logic               irq_n_o
);
  logic [NUM_SRC-1:0] evt, stat, mask;
  logic               exst, irq;

  assign evt = {err_evt_i, rst_done_i};

  mphy_evt_status #(.AW(AW), .DW(DW)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .stat_o  (stat),
    .mask_o  (mask),
    .exst_o  (exst)
  );

  mphy_ftr_track #(.CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_cnt_i   (rx_cnt_i),
    .tx_cnt_i   (tx_cnt_i),
    .exst_i     (exst),
    .ftr_sent_i (ftr_sent_i),
    .hdr_rcvd_i (hdr_rcvd_i),
    .irq_o      (irq)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(STAT_ADR))      reg_rdata_o[NUM_SRC-1:0] = stat;
    else if (reg_addr_i == AW'(MASK_ADR)) reg_rdata_o[NUM_SRC-1:0] = mask;
  end

  assign exst_o  = exst;
  assign irq_n_o = ~irq;

  p_reset_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_n_o);
endmodule

// File: tb/test_mphy_irq_ctrl.sv
module test_mphy_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;
  localparam int AW = 2;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] err_evt = '0;
  logic rst_done = 1'b0;
  logic [CNT_W-1:0] rx_cnt = '0, tx_cnt = '0;
  logic ftr = 1'b0, hdr = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic exst, irq_n;
  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mphy_irq_ctrl #(.CNT_W(CNT_W), .AW(AW), .DW(DW)) i_mphy_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt), .rst_done_i(rst_done),
    .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt), .ftr_sent_i(ftr), .hdr_rcvd_i(hdr),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .exst_o(exst), .irq_n_o(irq_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr = 1'b1; addr = a; wdata = d; tick(); wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_err(input logic [3:0] b);
    err_evt = b; tick(); err_evt = '0;
  endtask

  task automatic footer(input int rx, input int tx);
    rx_cnt = CNT_W'(rx); tx_cnt = CNT_W'(tx); ftr = 1'b1; tick(); ftr = 1'b0;
  endtask

  task automatic header();
    hdr = 1'b1; tick(); hdr = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    reg_read(0, d); chk("R8 status after reset", d, 32'h0);
    reg_read(1, d); chk("R8 mask after reset", d, 32'h1E);
    chk("R8 irq_n after reset", 32'(irq_n), 1);
    chk("R8 exst after reset", 32'(exst), 0);
  endtask

  task automatic t_rstdone();
    logic [DW-1:0] d;
    rst_done = 1'b1; tick(); rst_done = 1'b0;
    reg_read(0, d); chk("R6 reset-complete bit", d, 32'h01);
    chk("R6 exst with default mask", 32'(exst), 1);
    tick(); chk("R3 irq from reset-complete", 32'(irq_n), 0);
    header(); chk("R4 header releases irq", 32'(irq_n), 1);
    reg_write(0, 32'h01); reg_read(0, d); chk("R7 clear reset-complete", d, 32'h0);
    reg_write(1, 32'h1F); reg_read(1, d); chk("R6 mask bit0 not writable", d, 32'h1E);
  endtask

  task automatic t_rx();
    footer(0, 3);
    rx_cnt = 2; tick(); chk("R1 rx chunks appear", 32'(irq_n), 0);
    header(); tick(2); chk("R4 no refire before footer", 32'(irq_n), 1);
  endtask

  task automatic t_tx();
    footer(2, 0);
    tx_cnt = 4; tick(); chk("R2 tx credits appear", 32'(irq_n), 0);
    header(); chk("R4 release after tx irq", 32'(irq_n), 1);
  endtask

  task automatic t_no_fire();
    footer(2, 4);
    rx_cnt = 3; tick(3); chk("R1 nonzero footer does not arm", 32'(irq_n), 1);
  endtask

  task automatic t_errors();
    logic [DW-1:0] d;
    reg_write(1, 32'h0); footer(2, 4);
    pulse_err(4'b0100); reg_read(0, d); chk("R5 loss of framing bit3", d, 32'h08);
    chk("R5 unmasked exst", 32'(exst), 1);
    tick(); chk("R3 irq from error", 32'(irq_n), 0);
    header(); reg_write(0, 32'h08);
    reg_write(1, 32'h1E); footer(2, 4);
    pulse_err(4'b1000); reg_read(0, d); chk("R5 header error bit4", d, 32'h10);
    chk("R5 masked source no exst", 32'(exst), 0);
    tick(2); chk("R5 masked source no irq", 32'(irq_n), 1);
    reg_write(0, 32'h10);
  endtask

  task automatic t_w1c();
    logic [DW-1:0] d;
    pulse_err(4'b0011); reg_read(0, d); chk("R5 tx proto and rx ovf bits", d, 32'h06);
    reg_write(0, 32'h0); reg_read(0, d); chk("R7 zero write no effect", d, 32'h06);
    reg_write(0, 32'h02); reg_read(0, d); chk("R7 clear one bit only", d, 32'h04);
    reg_write(0, 32'h04); reg_read(0, d); chk("R7 clear last bit", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    pulse_err(4'b0001);
    err_evt = 4'b0001; reg_write(0, 32'h02); err_evt = '0;
    reg_read(0, d); chk("R9 event beats clear", d, 32'h02);
    reg_write(0, 32'h02);
    footer(0, 4); tick();
    rx_cnt = 2; hdr = 1'b1; tick(); hdr = 1'b0;
    chk("R4 header wins over fire", 32'(irq_n), 1);
    tick(2); chk("R4 stays released", 32'(irq_n), 1);
  endtask

  task automatic t_addr();
    logic [DW-1:0] d;
    reg_read(2, d); chk("R10 addr2 reads zero", d, 32'h0);
    reg_read(3, d); chk("R10 addr3 reads zero", d, 32'h0);
    reg_write(3, 32'hFFFF_FFFF); reg_write(2, 32'hFFFF_FFFF);
    reg_read(1, d); chk("R10 mask untouched", d, 32'h1E);
    reg_read(0, d); chk("R10 status untouched", d, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    tick(2); rst_n = 1'b1; tick();
    t_reset();
    t_rstdone();
    t_rx();
    t_tx();
    t_no_fire();
    t_errors();
    t_w1c();
    t_collide();
    t_addr();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule